// File: doc/BRIEF.md
# Memory-to-hex-record dump engine

This block takes over a shared memory bus with an active-low request/acknowledge handshake. It reads the memory windows picked by a page mask one byte at a time. It turns their contents into ASCII hexadecimal text records and hands them to a downstream serial transmitter one character at a time. Each record is a colon, then a byte count, a 16-bit start address, record type 00, the data bytes and a two's-complement checksum, all as uppercase hex digits and followed by CR and LF. A closing end-of-file record ends every complete dump.

The controller is a small sequencer. Each state carries a condition selector: none, bus wait, transmitter ready, or send. The character strobe is not a separate control bit. It is decoded from the selector holding the send code. A character leaves only after the transmitter-ready input has been seen high on three clock samples in a row. Nothing in the block depends on the clock frequency. A 16-bit debug word exposes the controller state, so the sequence can be followed one step at a time.

Top module: `mem_hex_dumper`

## Requirements
- R1: While `rst_ni` is low and right after it, `busy_o`=0, `bus_ack_n_o`=1, `rd_n_o`=1 and `tx_send_o`=0.
- R2: A `start_i` pulse while idle is accepted only if `bus_req_n_i` is low in that cycle. Otherwise it is ignored and `busy_o` stays 0.
- R3: From the cycle after an accepted start until after the last character, `busy_o`=1 and `bus_ack_n_o`=0. When idle, both are released (`busy_o`=0, `bus_ack_n_o`=1, `rd_n_o`=1).
- R4: A read drives `rd_n_o` low with the address on `addr_o` while the bus is acknowledged. `rd_n_o` stays low while `wait_n_i` is low. `data_i` is taken in the cycle in which `wait_n_i` is high, so the strobe lasts exactly (wait cycles + 1) cycles.
- R5: Bit k of `page_mask_i` selects the window that starts at k·2^PAGE_W. Selected windows are dumped in ascending address order, and unselected windows produce no records.
- R6: `long_rec_i`=0 gives 16 data bytes per record and 1 gives 32. The value is sampled at start.
- R7: Each data record is ':' then count, address high, address low, 00, the data bytes and the checksum, each as two uppercase hex digits (0-9, A-F), then 0x0D 0x0A. The checksum is the negation of the 8-bit sum of the other bytes.
- R8: A finished dump ends with ":00000001FF" CR LF and then goes idle. An all-zero mask yields only this record.
- R9: A character is sent only after `tx_ready_i` has been high on three consecutive clock samples. A low sample restarts the count.
- R10: `tx_send_o` is a one-cycle pulse, and `tx_char_o` holds the character's ASCII code in that cycle.
- R11: If `bus_req_n_i` goes high during a dump, a read in progress is completed. The engine then returns to idle with the bus released, and no further characters are sent.
- R12: `dbg_o[15:12]` holds the controller state code. It is 0 when idle and non-zero during a dump.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse |
| page_mask_i | input | 2^(ADDR_W-PAGE_W) | One enable bit per memory window |
| long_rec_i | input | 1 | 0: 16-byte records, 1: 32-byte records |
| bus_req_n_i | input | 1 | Bus request, active low |
| bus_ack_n_o | output | 1 | Bus acknowledge, active low |
| wait_n_i | input | 1 | Read wait, active low |
| rd_n_o | output | 1 | Read strobe, active low |
| addr_o | output | ADDR_W | Address bus, zero when not owned |
| data_i | input | 8 | Data bus |
| busy_o | output | 1 | Dump in progress |
| dbg_o | output | 16 | Controller state word |
| tx_ready_i | input | 1 | Transmitter ready |
| tx_send_o | output | 1 | Character strobe |
| tx_char_o | output | 8 | ASCII character |

## Verification
The bench models a memory that returns 0xEE while `wait_n_i` is low. A design that sampled data too early would then print wrong digits, and a strobe that is too short or too long shows up in the per-read length check. The transmitter-ready pattern has runs of only two highs. Sending on a two-sample count would fire inside such a run, and the history kept for every strobe would catch it. The abort test drops the request in the middle of a read stretched by wait states. A block that cut the read short, or that carried on to the closing record, would either raise the strobe early or keep emitting characters. An all-zero mask and a full mask exercise the window skipping and the end of the address space.

// File: rtl/hexdump_pkg.sv
package hexdump_pkg;

    typedef enum logic [3:0] {
        ST_IDLE  = 4'd0,
        ST_SEEK  = 4'd1,
        ST_PICK  = 4'd2,
        ST_READ  = 4'd3,
        ST_READY = 4'd4,
        ST_SEND  = 4'd5
    } st_e;

    typedef enum logic [3:0] {
        IT_COLON = 4'd0,
        IT_CNT   = 4'd1,
        IT_AHI   = 4'd2,
        IT_ALO   = 4'd3,
        IT_TYPE  = 4'd4,
        IT_DATA  = 4'd5,
        IT_CSUM  = 4'd6,
        IT_CR    = 4'd7,
        IT_LF    = 4'd8
    } item_e;

    // sequencer condition selector; the send strobe is decoded from CS_SEND
    typedef enum logic [1:0] {
        CS_NONE  = 2'd0,
        CS_WAIT  = 2'd1,
        CS_READY = 2'd2,
        CS_SEND  = 2'd3
    } cond_e;

    localparam logic [7:0] CH_COLON = 8'h3A;
    localparam logic [7:0] CH_CR    = 8'h0D;
    localparam logic [7:0] CH_LF    = 8'h0A;

    function automatic logic [7:0] hex_ascii(input logic [3:0] n);
        return (n < 4'd10) ? (8'h30 + {4'h0, n}) : (8'h37 + {4'h0, n});
    endfunction

endpackage

// File: rtl/hd_ready_filter.sv
module hd_ready_filter #(
    parameter int SAMPLES = 3
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    input  logic ready_i,
    output logic ok_o
);
    localparam int CW = $clog2(SAMPLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        ok_o  = en_i && ready_i && (cnt_q == CW'(SAMPLES - 1));
        cnt_d = cnt_q;
        if (!en_i || !ready_i || ok_o) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/hd_page_seek.sv
module hd_page_seek #(
    parameter int ADDR_W = 16,
    parameter int PAGE_W = 13,
    parameter int NPAGE  = 1 << (ADDR_W - PAGE_W)
) (
    input  logic [ADDR_W:0]   cur_i,
    input  logic [NPAGE-1:0]  mask_i,
    output logic              hit_o,
    output logic              end_o,
    output logic [ADDR_W:0]   skip_o
);
    localparam int IDX_W = ADDR_W - PAGE_W;
    localparam logic [ADDR_W:0] OFS_ONES = (ADDR_W + 1)'((1 << PAGE_W) - 1);

    logic [IDX_W-1:0] idx;
    logic [NPAGE-1:0] sel;

    assign idx = cur_i[ADDR_W-1:PAGE_W];

    generate
        for (genvar k = 0; k < NPAGE; k++) begin : g_page
            assign sel[k] = mask_i[k] && (idx == IDX_W'(k));
        end
    endgenerate

    assign end_o  = cur_i[ADDR_W];
    assign hit_o  = (|sel) && !cur_i[ADDR_W];
    assign skip_o = (cur_i | OFS_ONES) + 1'b1;
endmodule

// File: rtl/hd_char_mux.sv
module hd_char_mux
    import hexdump_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  item_e             item_i,
    input  logic              nib_i,
    input  logic              eof_i,
    input  logic [7:0]        len_i,
    input  logic [ADDR_W-1:0] rec_addr_i,
    input  logic [7:0]        data_i,
    input  logic [7:0]        sum_i,
    output logic [7:0]        byte_o,
    output logic [7:0]        char_o
);
    logic [15:0] rec16;
    assign rec16 = 16'(rec_addr_i);

    always_comb begin
        case (item_i)
            IT_CNT:  byte_o = eof_i ? 8'h00 : len_i;
            IT_AHI:  byte_o = eof_i ? 8'h00 : rec16[15:8];
            IT_ALO:  byte_o = eof_i ? 8'h00 : rec16[7:0];
            IT_TYPE: byte_o = {7'b0, eof_i};
            IT_DATA: byte_o = data_i;
            IT_CSUM: byte_o = 8'h00 - sum_i;
            default: byte_o = 8'h00;
        endcase
        case (item_i)
            IT_COLON: char_o = CH_COLON;
            IT_CR:    char_o = CH_CR;
            IT_LF:    char_o = CH_LF;
            default:  char_o = hex_ascii(nib_i ? byte_o[3:0] : byte_o[7:4]);
        endcase
    end
endmodule

// File: rtl/mem_hex_dumper.sv
module mem_hex_dumper
    import hexdump_pkg::*;
#(
    parameter int ADDR_W        = 16,
    parameter int PAGE_W        = 13,
    parameter int LEN_SHORT     = 16,
    parameter int LEN_LONG      = 32,
    parameter int READY_SAMPLES = 3
) (
    input  logic                             clk_i,
    input  logic                             rst_ni,
    input  logic                             start_i,
    input  logic [(1<<(ADDR_W-PAGE_W))-1:0]  page_mask_i,
    input  logic                             long_rec_i,
    input  logic                             bus_req_n_i,
    output logic                             bus_ack_n_o,
    input  logic                             wait_n_i,
    output logic                             rd_n_o,
    output logic [ADDR_W-1:0]                addr_o,
    input  logic [7:0]                       data_i,
    output logic                             busy_o,
    output logic [15:0]                      dbg_o,
    input  logic                             tx_ready_i,
    output logic                             tx_send_o,
    output logic [7:0]                       tx_char_o
);
    localparam int NPAGE = 1 << (ADDR_W - PAGE_W);
    localparam int CNT_W = $clog2(LEN_LONG);

    typedef struct packed {
        st_e                st;
        item_e              item;
        logic               nib;
        logic               eof;
        logic               lng;
        logic [NPAGE-1:0]   mask;
        logic [ADDR_W:0]    cur;
        logic [ADDR_W-1:0]  rec;
        logic [CNT_W-1:0]   bcnt;
        logic [7:0]         sum;
        logic [7:0]         data;
        logic [7:0]         chr;
    } regs_t;

    regs_t r_d, r_q;

    cond_e           cond;
    logic            rdy_ok;
    logic            pg_hit, pg_end;
    logic [ADDR_W:0] pg_skip;
    logic [7:0]      len_byte;
    logic [CNT_W-1:0] last_idx;
    logic [7:0]      cur_byte, cur_char;

    assign len_byte = r_q.lng ? 8'(LEN_LONG) : 8'(LEN_SHORT);
    assign last_idx = r_q.lng ? CNT_W'(LEN_LONG - 1) : CNT_W'(LEN_SHORT - 1);

    always_comb begin
        case (r_q.st)
            ST_READ:  cond = CS_WAIT;
            ST_READY: cond = CS_READY;
            ST_SEND:  cond = CS_SEND;
            default:  cond = CS_NONE;
        endcase
    end

    hd_ready_filter #(.SAMPLES(READY_SAMPLES)) u_rdy (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .en_i    (cond == CS_READY),
        .ready_i (tx_ready_i),
        .ok_o    (rdy_ok)
    );

    hd_page_seek #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .NPAGE(NPAGE)) u_seek (
        .cur_i  (r_q.cur),
        .mask_i (r_q.mask),
        .hit_o  (pg_hit),
        .end_o  (pg_end),
        .skip_o (pg_skip)
    );

    hd_char_mux #(.ADDR_W(ADDR_W)) u_mux (
        .item_i     (r_q.item),
        .nib_i      (r_q.nib),
        .eof_i      (r_q.eof),
        .len_i      (len_byte),
        .rec_addr_i (r_q.rec),
        .data_i     (r_q.data),
        .sum_i      (r_q.sum),
        .byte_o     (cur_byte),
        .char_o     (cur_char)
    );

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_IDLE: begin
                if (start_i && !bus_req_n_i) begin
                    r_d.st   = ST_SEEK;
                    r_d.mask = page_mask_i;
                    r_d.lng  = long_rec_i;
                    r_d.cur  = '0;
                    r_d.eof  = 1'b0;
                end
            end
            ST_SEEK: begin
                if (pg_end || pg_hit) begin
                    r_d.eof  = pg_end;
                    r_d.rec  = r_q.cur[ADDR_W-1:0];
                    r_d.item = IT_COLON;
                    r_d.nib  = 1'b0;
                    r_d.bcnt = '0;
                    r_d.sum  = 8'h00;
                    r_d.st   = ST_PICK;
                end else begin
                    r_d.cur = pg_skip;
                end
            end
            ST_PICK: begin
                if (r_q.item == IT_DATA && !r_q.nib) begin
                    r_d.st = ST_READ;
                end else begin
                    r_d.chr = cur_char;
                    r_d.st  = ST_READY;
                end
            end
            ST_READ: begin
                if (wait_n_i) begin
                    r_d.data = data_i;
                    r_d.chr  = hex_ascii(data_i[7:4]);
                    r_d.st   = bus_req_n_i ? ST_IDLE : ST_READY;
                end
            end
            ST_READY: begin
                if (rdy_ok) begin
                    r_d.st = ST_SEND;
                end
            end
            ST_SEND: begin
                r_d.st = ST_PICK;
                case (r_q.item)
                    IT_COLON: r_d.item = IT_CNT;
                    IT_CR:    r_d.item = IT_LF;
                    IT_LF:    r_d.st   = r_q.eof ? ST_IDLE : ST_SEEK;
                    default: begin
                        if (!r_q.nib) begin
                            r_d.nib = 1'b1;
                        end else begin
                            r_d.nib = 1'b0;
                            if (r_q.item != IT_CSUM) begin
                                r_d.sum = r_q.sum + cur_byte;
                            end
                            case (r_q.item)
                                IT_CNT:  r_d.item = IT_AHI;
                                IT_AHI:  r_d.item = IT_ALO;
                                IT_ALO:  r_d.item = IT_TYPE;
                                IT_TYPE: r_d.item = r_q.eof ? IT_CSUM : IT_DATA;
                                IT_DATA: begin
                                    r_d.cur  = r_q.cur + 1'b1;
                                    r_d.bcnt = r_q.bcnt + 1'b1;
                                    if (r_q.bcnt == last_idx) begin
                                        r_d.item = IT_CSUM;
                                    end
                                end
                                default: r_d.item = IT_CR;
                            endcase
                        end
                    end
                endcase
            end
            default: r_d.st = ST_IDLE;
        endcase
        // bus withdrawn: leave at once unless a read is still open
        if (bus_req_n_i && r_q.st != ST_IDLE && r_q.st != ST_READ) begin
            r_d.st = ST_IDLE;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o      = (r_q.st != ST_IDLE);
    assign bus_ack_n_o = !busy_o;
    assign rd_n_o      = (r_q.st != ST_READ);
    assign addr_o      = busy_o ? r_q.cur[ADDR_W-1:0] : '0;
    assign tx_send_o   = (cond == CS_SEND);
    assign tx_char_o   = r_q.chr;
    assign dbg_o       = {r_q.st, r_q.item, cond, r_q.nib, r_q.eof, r_q.lng,
                          bus_ack_n_o, busy_o, 1'b0};
endmodule

// File: rtl/hexdump_chk.sv
module hexdump_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic bus_req_n_i,
    input logic bus_ack_n_o,
    input logic wait_n_i,
    input logic rd_n_o,
    input logic busy_o,
    input logic tx_ready_i,
    input logic tx_send_o
);
    // R4
    read_owns_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_n_o |-> !bus_ack_n_o);

    // R4
    read_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!rd_n_o && !wait_n_i) |=> !rd_n_o);

    // R10
    send_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tx_send_o |=> !tx_send_o);

    // R9
    ready_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tx_send_o |-> ($past(tx_ready_i, 1) && $past(tx_ready_i, 2) && $past(tx_ready_i, 3)));

    // R3
    idle_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> (bus_ack_n_o && rd_n_o && !tx_send_o));

    // R2
    start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && bus_req_n_i) |=> !busy_o);

    // R11
    abort_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && bus_req_n_i && rd_n_o) |=> !busy_o);
endmodule

bind mem_hex_dumper hexdump_chk u_hexdump_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_req_n_i (bus_req_n_i),
    .bus_ack_n_o (bus_ack_n_o),
    .wait_n_i    (wait_n_i),
    .rd_n_o      (rd_n_o),
    .busy_o      (busy_o),
    .tx_ready_i  (tx_ready_i),
    .tx_send_o   (tx_send_o)
);

// File: tb/mem_hex_dumper_tb_top.sv
module mem_hex_dumper_tb_top;
    localparam int AW = 10;
    localparam int PW = 7;
    localparam int NP = 1 << (AW - PW);
    localparam int PSZ = 1 << PW;

    typedef struct packed {
        logic [7:0] mask;
        logic       lng;
        logic [1:0] wlen;
        logic [1:0] rmode;
        logic [7:0] nrec;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{8'h01, 1'b0, 2'd0, 2'd0, 8'd8},
        '{8'h81, 1'b1, 2'd2, 2'd0, 8'd8},
        '{8'h00, 1'b0, 2'd1, 2'd0, 8'd0},
        '{8'h24, 1'b0, 2'd1, 2'd1, 8'd16},
        '{8'hFF, 1'b1, 2'd0, 2'd0, 8'd32}
    };

    logic clk_i = 1'b0;
    logic rst_ni = 1'b0;
    logic start_i = 1'b0;
    logic [NP-1:0] page_mask_i = '0;
    logic long_rec_i = 1'b0;
    logic bus_req_n_i = 1'b1;
    logic bus_ack_n_o;
    logic wait_n_i = 1'b1;
    logic rd_n_o;
    logic [AW-1:0] addr_o;
    logic [7:0] data_i;
    logic busy_o;
    logic [15:0] dbg_o;
    logic tx_ready_i = 1'b1;
    logic tx_send_o;
    logic [7:0] tx_char_o;

    always #2.5 clk_i = ~clk_i;

    mem_hex_dumper #(.ADDR_W(AW), .PAGE_W(PW)) dut_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .page_mask_i(page_mask_i),
        .long_rec_i(long_rec_i), .bus_req_n_i(bus_req_n_i), .bus_ack_n_o(bus_ack_n_o),
        .wait_n_i(wait_n_i), .rd_n_o(rd_n_o), .addr_o(addr_o), .data_i(data_i),
        .busy_o(busy_o), .dbg_o(dbg_o), .tx_ready_i(tx_ready_i), .tx_send_o(tx_send_o),
        .tx_char_o(tx_char_o)
    );

    int n_checks = 0;
    int n_fails = 0;
    int wait_len = 0;
    int rmode = 0;
    int cyc = 0;
    int rd_cnt = 0;
    int cap_n = 0;
    logic [7:0] cap_buf [0:4095];
    logic [7:0] exp_buf [0:4095];
    int exp_n;
    logic [7:0] run_sum;
    logic [2:0] hist = 3'b000;
    logic prev_send = 1'b0;

    function automatic logic [7:0] mem_val(input int a);
        return 8'((a * 29 + 7) ^ (a >> 3));
    endfunction

    assign data_i = (!rd_n_o && wait_n_i) ? mem_val(int'(addr_o)) : 8'hEE;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // transmitter ready model: 0 always high, 1 runs of 2 and 3 highs, 2 always low
    always @(negedge clk_i) begin
        cyc++;
        case (rmode)
            1: tx_ready_i <= ((cyc % 7) inside {0, 1, 3, 4, 5});
            2: tx_ready_i <= 1'b0;
            default: tx_ready_i <= 1'b1;
        endcase
    end

    always @(posedge clk_i) hist <= {hist[1:0], tx_ready_i};

    // wait-state model and strobe length check (R4)
    always @(negedge clk_i) begin
        if (!rd_n_o) begin
            rd_cnt = rd_cnt + 1;
        end else begin
            if (rd_cnt != 0) check(rd_cnt == wait_len + 1, "R4 strobe length", rd_cnt, wait_len + 1);
            rd_cnt = 0;
        end
        wait_n_i <= rd_n_o ? 1'b1 : (rd_cnt > wait_len);
    end

    // character capture with strobe checks
    always @(negedge clk_i) begin
        if (tx_send_o) begin
            check(hist == 3'b111, "R9 ready history", int'(hist), 7);
            check(!prev_send, "R10 single pulse", int'(prev_send), 0);
            check((tx_char_o >= 8'h30 && tx_char_o <= 8'h3A) || (tx_char_o >= 8'h41 && tx_char_o <= 8'h46)
                  || tx_char_o == 8'h0D || tx_char_o == 8'h0A, "R10 char valid", int'(tx_char_o), 8'h30);
            cap_buf[cap_n % 4096] = tx_char_o;
            cap_n++;
        end
        prev_send = tx_send_o;
    end

    initial begin
        while (cyc < 190000) @(posedge clk_i);
        n_fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    end

    task automatic push_raw(input logic [7:0] c);
        exp_buf[exp_n] = c;
        exp_n++;
    endtask

    task automatic push_hex(input logic [7:0] b, input bit add);
        logic [3:0] hi, lo;
        hi = b[7:4];
        lo = b[3:0];
        push_raw(hi < 10 ? 8'h30 + 8'(hi) : 8'h37 + 8'(hi));
        push_raw(lo < 10 ? 8'h30 + 8'(lo) : 8'h37 + 8'(lo));
        if (add) run_sum = run_sum + b;
    endtask

    task automatic build_expected(input logic [7:0] mask, input logic lng);
        int len;
        len = lng ? 32 : 16;
        exp_n = 0;
        for (int p = 0; p < NP; p++) begin
            if (mask[p]) begin
                for (int a = p * PSZ; a < (p + 1) * PSZ; a += len) begin
                    run_sum = 8'h00;
                    push_raw(8'h3A);
                    push_hex(8'(len), 1);
                    push_hex(8'(a >> 8), 1);
                    push_hex(8'(a), 1);
                    push_hex(8'h00, 1);
                    for (int i = 0; i < len; i++) push_hex(mem_val(a + i), 1);
                    push_hex(8'h00 - run_sum, 0);
                    push_raw(8'h0D);
                    push_raw(8'h0A);
                end
            end
        end
        push_raw(8'h3A);
        push_hex(8'h00, 0); push_hex(8'h00, 0); push_hex(8'h00, 0);
        push_hex(8'h01, 0); push_hex(8'hFF, 0);
        push_raw(8'h0D);
        push_raw(8'h0A);
    endtask

    task automatic pulse_start();
        @(negedge clk_i) start_i = 1'b1;
        @(negedge clk_i) start_i = 1'b0;
    endtask

    task automatic wait_idle(input int limit);
        for (int i = 0; i < limit; i++) begin
            @(negedge clk_i);
            if (!busy_o) break;
        end
    endtask

    task automatic compare_stream(input int base, input int nrec, input string tag);
        int got, colons, bad;
        got = cap_n - base;
        check(got == exp_n, {tag, " R6 char count"}, got, exp_n);
        colons = 0;
        bad = -1;
        for (int i = 0; i < got && i < exp_n; i++) begin
            if (cap_buf[(base + i) % 4096] == 8'h3A) colons++;
            if (bad < 0 && cap_buf[(base + i) % 4096] != exp_buf[i]) bad = i;
        end
        check(colons == nrec + 1, {tag, " R5 record count"}, colons - 1, nrec);
        if (bad >= 0)
            check(0, {tag, " R7 stream"}, int'(cap_buf[(base + bad) % 4096]), int'(exp_buf[bad]));
        else
            check(1, {tag, " R7 stream"}, 0, 0);
        if (got >= 13) begin
            bad = 0;
            for (int i = 0; i < 13; i++)
                if (cap_buf[(base + got - 13 + i) % 4096] != exp_buf[exp_n - 13 + i]) bad = 1;
            check(bad == 0, {tag, " R8 end record"}, bad, 0);
        end else begin
            check(0, {tag, " R8 end record"}, got, 13);
        end
    endtask

    initial begin
        int base;
        // R1: reset state
        repeat (3) @(negedge clk_i);
        check(!busy_o && bus_ack_n_o && rd_n_o && !tx_send_o, "R1 in reset",
              int'({busy_o, bus_ack_n_o, rd_n_o, tx_send_o}), 4'b0110);
        rst_ni = 1'b1;
        @(negedge clk_i);
        check(!busy_o && bus_ack_n_o && rd_n_o && !tx_send_o, "R1 after reset",
              int'({busy_o, bus_ack_n_o, rd_n_o, tx_send_o}), 4'b0110);
        check(dbg_o[15:12] == 4'd0, "R12 idle code", int'(dbg_o[15:12]), 0);

        // vector table
        foreach (VECS[v]) begin
            page_mask_i = VECS[v].mask;
            long_rec_i  = VECS[v].lng;
            wait_len    = int'(VECS[v].wlen);
            rmode       = int'(VECS[v].rmode);
            bus_req_n_i = 1'b0;
            build_expected(VECS[v].mask, VECS[v].lng);
            base = cap_n;
            pulse_start();
            check(busy_o && !bus_ack_n_o, "R3 busy and ack after start",
                  int'({busy_o, bus_ack_n_o}), 2'b10);
            check(dbg_o[15:12] != 4'd0, "R12 active code", int'(dbg_o[15:12]), 1);
            wait_idle(60000);
            check(!busy_o && bus_ack_n_o && rd_n_o, "R3 released at end",
                  int'({busy_o, bus_ack_n_o, rd_n_o}), 3'b011);
            compare_stream(base, int'(VECS[v].nrec), $sformatf("vec%0d", v));
        end
        rmode = 0;

        // R11: withdraw the bus during a stretched read
        page_mask_i = 8'hFF;
        long_rec_i = 1'b0;
        wait_len = 3;
        bus_req_n_i = 1'b0;
        pulse_start();
        for (int i = 0; i < 200; i++) begin
            @(negedge clk_i);
            if (!rd_n_o) break;
        end
        bus_req_n_i = 1'b1;
        @(negedge clk_i);
        check(!rd_n_o && !bus_ack_n_o, "R11 read completes", int'({rd_n_o, bus_ack_n_o}), 0);
        base = cap_n;
        wait_idle(10);
        check(!busy_o && bus_ack_n_o && rd_n_o, "R11 released",
              int'({busy_o, bus_ack_n_o, rd_n_o}), 3'b011);
        repeat (30) @(negedge clk_i);
        check(cap_n == base, "R11 no chars after abort", cap_n - base, 0);

        // R2: start while request is inactive
        pulse_start();
        repeat (20) @(negedge clk_i);
        check(!busy_o && bus_ack_n_o, "R2 start ignored", int'({busy_o, bus_ack_n_o}), 2'b01);
        check(cap_n == base, "R2 nothing sent", cap_n - base, 0);

        // R9: ready held low blocks every character
        wait_len = 0;
        rmode = 2;
        page_mask_i = 8'h01;
        bus_req_n_i = 1'b0;
        build_expected(8'h01, 1'b0);
        base = cap_n;
        pulse_start();
        repeat (60) @(negedge clk_i);
        check(cap_n == base, "R9 no send while ready low", cap_n - base, 0);
        check(busy_o, "R3 stays busy while stalled", int'(busy_o), 1);
        check(dbg_o[15:12] == 4'd4, "R12 waiting-ready code", int'(dbg_o[15:12]), 4);
        rmode = 0;
        wait_idle(60000);
        compare_stream(base, 8, "stall");

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    end
endmodule